// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer Bank

The block holds three independent down-counting timers behind one word-addressed register port. The upper two bits of the word address pick a timer and the lower six bits pick a register inside it, so each timer owns a 256-byte window on a byte-addressed bus (byte offset bits [9:2] form the word address). Each timer counts only on its own externally supplied tick-enable pulse, optionally divided by a prescaler. When a timer runs out, it raises a sticky raw flag and drives an interrupt line, which a per-timer enable bit can mask.

Three behaviours at expiry are available. One-shot parks the count at zero. Periodic restarts from the stored reload value. Free-running wraps to the all-ones value of the selected 16-bit or 32-bit width. Software can start a fresh count by writing the load register. It can also change only the next reload value through a background-load register, which leaves the running count alone.

Top module: `tick_timer_bank`

## Requirements
- R1: Word address bits [7:6] select timer 0..2 and bits [5:0] select a register: 0 load, 1 current count, 2 control, 3 flag clear, 4 raw flag, 5 masked flag, 6 background load. Timer select 3 and register indices 3 and 7..63 read as zero. Writes to timer select 3 are ignored.
- R2: After a synchronous reset, every control register reads 0x20, every count reads 0xFFFFFFFF, every load reads 0, every raw flag reads 0 and all interrupt lines are low.
- R3: A write to index 0 sets both the reload value and the count from the next cycle on. A write to index 6 changes only the reload value.
- R4: A timer whose control bit 7 is clear holds its count. Writes to index 1 never change the count.
- R5: A running timer takes one step per qualifying tick. With control bits [3:2] at 00 or 11, every tick qualifies. With 01, every 16th tick qualifies. With 10, every 256th tick qualifies. Writing load or control restarts the tick division. A step from a count above 1 subtracts 1. In 16-bit mode the full 32-bit count still decrements.
- R6: Expiry is a step taken from a count of 1, or from 0 when not in one-shot mode. Expiry sets the raw flag (index 4, bit 0).
- R7: In one-shot mode (control bit 0 = 1, which takes priority over bit 6), expiry leaves the count at 0. Later steps keep it at 0 and do not set the flag again.
- R8: In periodic mode (bit 6 = 1, bit 0 = 0), expiry loads the count from the reload value held before that cycle's writes.
- R9: In free-running mode (bits 6 and 0 clear), expiry loads 0xFFFFFFFF when bit 1 = 1 and 0x0000FFFF when bit 1 = 0.
- R10: Any write to index 3 clears the raw flag. An expiry in the same cycle wins, and the flag stays set.
- R11: Index 5 and the interrupt line of a timer both equal its raw flag ANDed with control bit 5.
- R12: The three timers keep separate state. Ticks, writes and expiries of one timer never change another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Word address: [7:6] timer, [5:0] register index |
| reg_wr | input | 1 | Write strobe, one write per asserted cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tick_en | input | 3 | Per-timer tick-enable pulses |
| irq | output | 3 | Per-timer masked interrupt lines |

## Verification
Read data is combinational and is due in the same cycle the address is presented. A write, a counting step or an expiry changes state at the clock edge where it is sampled, so register contents, the raw flag and the interrupt lines show the new value in the following cycle. The bench applies inputs two nanoseconds after the rising edge. Directed reads sample one nanosecond later, which is before the next edge. A behavioural reference model updates on each rising edge and is compared with the read data and the interrupt lines at every falling edge, so each result is checked in the first cycle it is due. Prescaler phases, same-cycle clear against expiry, and background reload are driven to exact tick counts.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
    localparam int DATA_W  = 32;
    localparam int NUM_TMR = 3;
    localparam int SEL_W   = 2;
    localparam int IDX_W   = 6;
    localparam int ADDR_W  = SEL_W + IDX_W;
    localparam int PS_W    = 8;
    localparam int CTRL_W  = 8;
    localparam int NARROW_W = 16;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV16  = 2'd1,
        PS_DIV256 = 2'd2,
        PS_SPARE  = 2'd3
    } presc_e;

    typedef struct packed {
        logic   run;
        logic   periodic;
        logic   irq_en;
        logic   spare;
        presc_e presc;
        logic   wide;
        logic   single;
    } tctl_t;

    typedef enum logic [IDX_W-1:0] {
        RI_LOAD   = 6'd0,
        RI_VALUE  = 6'd1,
        RI_CTRL   = 6'd2,
        RI_ICLR   = 6'd3,
        RI_RAW    = 6'd4,
        RI_MASKED = 6'd5,
        RI_BGLOAD = 6'd6
    } ridx_e;

    typedef struct packed {
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] count;
        tctl_t             ctl;
        logic              raw;
    } tstate_t;

    localparam tctl_t CTL_RST = tctl_t'(8'h20);

    // last prescaler phase before a step is released
    function automatic logic [PS_W-1:0] presc_last(presc_e p);
        case (p)
            PS_DIV16:  return PS_W'(15);
            PS_DIV256: return PS_W'(255);
            default:   return '0;
        endcase
    endfunction

    // free-running wrap value for the selected width
    function automatic logic [DATA_W-1:0] wrap_val(logic wide);
        if (wide) return '1;
        return {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import ttb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   tick,
    input  presc_e div,
    output logic   fire
);
    logic [PS_W-1:0] phase;

    assign fire = tick && (phase == presc_last(div));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= '0;
        end else if (tick) begin
            phase <= fire ? '0 : phase + 1'b1;
        end
    end

    p_phase_bound_r5: assert property (@(posedge clk) disable iff (rst)
        phase <= presc_last(div));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import ttb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output logic [DATA_W-1:0] rword,
    output logic              irq
);
    tstate_t st;
    tstate_t nx;
    logic wr_load, wr_ctrl, wr_clr, wr_bg;
    logic fire, at_floor, parked, expire, decr;

    assign wr_load = wr_hit && (idx == RI_LOAD);
    assign wr_ctrl = wr_hit && (idx == RI_CTRL);
    assign wr_clr  = wr_hit && (idx == RI_ICLR);
    assign wr_bg   = wr_hit && (idx == RI_BGLOAD);

    tmr_prescale u_ps (
        .clk  (clk),
        .rst  (rst),
        .clr  (wr_load || wr_ctrl),
        .tick (tick && st.ctl.run),
        .div  (st.ctl.presc),
        .fire (fire)
    );

    assign at_floor = (st.count <= DATA_W'(1));
    assign parked   = st.ctl.single && (st.count == '0);
    assign expire   = fire && at_floor && !parked;
    assign decr     = fire && !at_floor;

    always_comb begin
        nx = st;
        if (expire) begin
            nx.raw = 1'b1;
            if (st.ctl.single)        nx.count = '0;
            else if (st.ctl.periodic) nx.count = st.reload;
            else                      nx.count = wrap_val(st.ctl.wide);
        end else if (decr) begin
            nx.count = st.count - DATA_W'(1);
        end
        if (wr_clr && !expire) nx.raw = 1'b0;
        if (wr_load) begin
            nx.reload = wdata;
            nx.count  = wdata;
        end
        if (wr_bg)   nx.reload = wdata;
        if (wr_ctrl) nx.ctl = tctl_t'(wdata[CTRL_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{reload: '0, count: '1, ctl: CTL_RST, raw: 1'b0};
        end else begin
            st <= nx;
        end
    end

    always_comb begin
        case (ridx_e'(idx))
            RI_LOAD, RI_BGLOAD: rword = st.reload;
            RI_VALUE:           rword = st.count;
            RI_CTRL:            rword = {{(DATA_W-CTRL_W){1'b0}}, st.ctl};
            RI_RAW:             rword = {{(DATA_W-1){1'b0}}, st.raw};
            RI_MASKED:          rword = {{(DATA_W-1){1'b0}}, st.raw && st.ctl.irq_en};
            default:            rword = '0;
        endcase
    end

    assign irq = st.raw && st.ctl.irq_en;

    p_off_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!st.ctl.run && !wr_load) |=> (st.count == $past(st.count)));

    p_single_park_r7: assert property (@(posedge clk) disable iff (rst)
        (parked && !wr_load) |=> (st.count == '0));

    p_raw_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (st.raw && !wr_clr) |=> st.raw);

    p_periodic_reload_r8: assert property (@(posedge clk) disable iff (rst)
        (expire && st.ctl.periodic && !st.ctl.single && !wr_load)
        |=> (st.count == $past(st.reload)));
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux #(
    parameter int N  = 3,
    parameter int W  = 32,
    parameter int SW = 2
) (
    input  logic [N-1:0][W-1:0] words,
    input  logic [SW-1:0]       sel,
    output logic [W-1:0]        rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (sel == SW'(i)) rdata = words[i];
        end
    end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
    import ttb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_TMR-1:0] tick_en,
    output logic [NUM_TMR-1:0] irq
);
    logic [SEL_W-1:0] sel;
    logic [IDX_W-1:0] idx;
    logic [NUM_TMR-1:0][DATA_W-1:0] words;

    assign sel = reg_addr[ADDR_W-1:IDX_W];
    assign idx = reg_addr[IDX_W-1:0];

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        tmr_core u_core (
            .clk    (clk),
            .rst    (rst),
            .wr_hit (reg_wr && (sel == SEL_W'(g))),
            .idx    (idx),
            .wdata  (reg_wdata),
            .tick   (tick_en[g]),
            .rword  (words[g]),
            .irq    (irq[g])
        );
    end

    tmr_rdmux #(.N(NUM_TMR), .W(DATA_W), .SW(SEL_W)) u_mux (
        .words (words),
        .sel   (sel),
        .rdata (reg_rdata)
    );
endmodule

// File: tb/tb_tick_timer_bank.sv
module tb_tick_timer_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [2:0]  tick = '0;
    wire  [31:0] rdata;
    wire  [2:0]  irq;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    bit rand_phase = 0;
    int rot = 0;

    logic [31:0] m_load [3];
    logic [31:0] m_cnt  [3];
    logic [7:0]  m_ctl  [3];
    bit          m_raw  [3];
    int          m_pre  [3];

    always #10 clk = ~clk;

    tick_timer_bank dut (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (addr),
        .reg_wr    (wr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .tick_en   (tick),
        .irq       (irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(int t, int ix);
        if (t > 2) return 32'h0;
        case (ix)
            0, 6: return m_load[t];
            1:    return m_cnt[t];
            2:    return {24'h0, m_ctl[t]};
            4:    return {31'h0, m_raw[t]};
            5:    return {31'h0, m_raw[t] && m_ctl[t][5]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(int t, int ix);
        if (t > 2) return "R1";
        case (ix)
            0, 6: return "R3";
            1:    return "R5";
            4:    return "R6";
            5:    return "R11";
            default: return "R1";
        endcase
    endfunction

    // behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        for (int t = 0; t < 3; t++) begin
            bit hit;
            bit fire;
            bit expd;
            int last;
            logic [31:0] c;
            hit = wr && (int'(addr[7:6]) == t);
            if (rst) begin
                m_load[t] = 0; m_cnt[t] = 32'hFFFF_FFFF; m_ctl[t] = 8'h20;
                m_raw[t] = 0; m_pre[t] = 0;
            end else begin
                fire = 0;
                c = m_cnt[t];
                if (m_ctl[t][7] && tick[t]) begin
                    last = (m_ctl[t][3:2] == 2'd1) ? 15 : (m_ctl[t][3:2] == 2'd2) ? 255 : 0;
                    if (m_pre[t] == last) begin fire = 1; m_pre[t] = 0; end
                    else m_pre[t]++;
                end
                expd = fire && (c <= 1) && !(m_ctl[t][0] && c == 0);
                if (expd) begin
                    m_raw[t] = 1;
                    if (m_ctl[t][0])      m_cnt[t] = 0;
                    else if (m_ctl[t][6]) m_cnt[t] = m_load[t];
                    else                  m_cnt[t] = m_ctl[t][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
                end else if (fire && c > 1) begin
                    m_cnt[t] = c - 1;
                end
                if (hit) begin
                    case (addr[5:0])
                        6'd0: begin m_load[t] = wdata; m_cnt[t] = wdata; m_pre[t] = 0; end
                        6'd2: begin m_ctl[t] = wdata[7:0]; m_pre[t] = 0; end
                        6'd3: if (!expd) m_raw[t] = 0;
                        6'd6: m_load[t] = wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(rand_phase ? "R12" : req_of(int'(addr[7:6]), int'(addr[5:0])),
                  rdata, m_read(int'(addr[7:6]), int'(addr[5:0])), "model rdata");
            check("R11", {29'h0, irq},
                  {29'h0, m_raw[2] && m_ctl[2][5], m_raw[1] && m_ctl[1][5], m_raw[0] && m_ctl[0][5]},
                  "model irq");
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wr_reg(int t, int ix, logic [31:0] d);
        addr = {t[1:0], ix[5:0]};
        wdata = d;
        wr = 1'b1;
        cyc();
        wr = 1'b0;
    endtask

    task automatic rd(int t, int ix, logic [31:0] exp, string req);
        addr = {t[1:0], ix[5:0]};
        #1;
        check(req, rdata, exp, "read");
    endtask

    task automatic pulse(logic [2:0] mask, int n);
        repeat (n) begin
            tick = mask;
            cyc();
        end
        tick = '0;
    endtask

    task automatic summary();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        // R2 reset state
        rd(0, 2, 32'h20, "R2");
        rd(1, 1, 32'hFFFF_FFFF, "R2");
        rd(2, 4, 32'h0, "R2");
        check("R2", {29'h0, irq}, 32'h0, "irq after reset");
        // R3 load and background load
        wr_reg(0, 0, 5);
        rd(0, 1, 5, "R3");
        rd(0, 0, 5, "R3");
        wr_reg(0, 6, 9);
        rd(0, 0, 9, "R3");
        rd(0, 1, 5, "R3");
        // R4 value write ignored, disabled timer holds
        wr_reg(0, 1, 32'h1234);
        rd(0, 1, 5, "R4");
        pulse(3'b111, 4);
        rd(0, 1, 5, "R4");
        // R1 decode holes
        wr_reg(3, 0, 32'hAB);
        rd(3, 0, 0, "R1");
        rd(1, 0, 0, "R1");
        rd(0, 7, 0, "R1");
        // R7 one-shot
        wr_reg(0, 0, 3);
        wr_reg(0, 2, 32'hA1);
        pulse(3'b001, 2);
        rd(0, 1, 1, "R5");
        rd(0, 4, 0, "R6");
        pulse(3'b001, 1);
        rd(0, 1, 0, "R7");
        rd(0, 4, 1, "R6");
        rd(0, 5, 1, "R11");
        check("R11", {31'h0, irq[0]}, 32'h1, "irq0 after one-shot");
        pulse(3'b001, 5);
        rd(0, 1, 0, "R7");
        // R10 clear
        wr_reg(0, 3, 0);
        rd(0, 4, 0, "R10");
        check("R10", {31'h0, irq[0]}, 32'h0, "irq0 after clear");
        // R9 free-running 16-bit, masked
        wr_reg(2, 0, 1);
        wr_reg(2, 2, 32'h80);
        pulse(3'b100, 1);
        rd(2, 1, 32'h0000_FFFF, "R9");
        rd(2, 4, 1, "R6");
        rd(2, 5, 0, "R11");
        check("R11", {31'h0, irq[2]}, 32'h0, "irq2 masked");
        pulse(3'b100, 1);
        rd(2, 1, 32'h0000_FFFE, "R5");
        // R9 free-running 32-bit from zero
        wr_reg(2, 0, 0);
        wr_reg(2, 2, 32'h82);
        pulse(3'b100, 1);
        rd(2, 1, 32'hFFFF_FFFF, "R9");
        // R8 periodic with background reload
        wr_reg(1, 0, 7);
        wr_reg(1, 2, 32'hC0);
        pulse(3'b010, 1);
        rd(1, 1, 6, "R5");
        wr_reg(1, 6, 2);
        rd(1, 1, 6, "R3");
        pulse(3'b010, 6);
        rd(1, 1, 2, "R8");
        // R5 prescaler /16 and /256
        wr_reg(1, 0, 100);
        wr_reg(1, 2, 32'hC4);
        pulse(3'b010, 15);
        rd(1, 1, 100, "R5");
        pulse(3'b010, 1);
        rd(1, 1, 99, "R5");
        wr_reg(1, 2, 32'hC8);
        pulse(3'b010, 255);
        rd(1, 1, 99, "R5");
        pulse(3'b010, 1);
        rd(1, 1, 98, "R5");
        // R10 expiry in the same cycle as clear keeps the flag
        wr_reg(0, 0, 1);
        wr_reg(0, 2, 32'hA1);
        addr = {2'd0, 6'd3};
        wr = 1'b1;
        tick = 3'b001;
        cyc();
        wr = 1'b0;
        tick = '0;
        rd(0, 4, 1, "R10");
        // R11 interrupt enable off
        wr_reg(0, 2, 32'h81);
        rd(0, 5, 0, "R11");
        check("R11", {31'h0, irq[0]}, 32'h0, "irq0 disabled");
        // R12 random traffic against the model
        rand_phase = 1;
        repeat (3000) begin
            tick = 3'($urandom);
            if ($urandom % 6 == 0) begin
                int t;
                int ix;
                t = int'($urandom % 4);
                ix = int'($urandom % 8);
                addr = {t[1:0], ix[5:0]};
                if (ix == 2)
                    wdata = (($urandom % 4 != 0) ? 32'h80 : 32'h0) | ($urandom % 128);
                else
                    wdata = $urandom % 50;
                wr = 1'b1;
            end else begin
                addr = {rot[1:0], 3'b000, rot[4:2]};
                rot++;
            end
            cyc();
            wr = 1'b0;
        end
        tick = '0;
        rand_phase = 0;
        repeat (20) begin
            addr = {rot[1:0], 3'b000, rot[4:2]};
            rot++;
            cyc();
        end
        summary();
    end
endmodule